// File: doc/BRIEF.md
# Flit Replay Retry Controller

This block adds link-level retry to a link that moves data in fixed-size flits. On the send side, every flit accepted from upstream gets the next 8-bit sequence number. It goes out to the link in the same cycle. A copy stays in a circular replay store until the link partner acknowledges it. A negative acknowledge makes the block resend every unacknowledged flit, oldest first, one per cycle. New traffic waits while that replay runs. Replay can be started again any number of times.

On the receive side, the block takes one status strobe per arriving flit: its sequence number and a pass flag from the CRC check. That check runs after the correction stage. An in-order passing flit is accepted and acknowledged. A failing flit is answered with a negative acknowledge that names the last good sequence number. A passing flit that is not the expected one is dropped in silence, so the stream resumes only when the expected flit arrives again.

Both directions carry a sequence number in their acknowledge messages. An acknowledge (positive or negative) naming sequence `s` releases every stored flit up to and including `s`.

Top module: `flit_retry_ctrl`

## Requirements
- R1: After reset, `up_ready_o` is 1, `tx_valid_o` is 0, `ackout_valid_o` is 0 and `rx_accept_o` is 0; both the send and the expected receive sequence start at 0.
- R2: A flit accepted from upstream (`up_valid_i` and `up_ready_o`) appears on `tx_data_o` in the same cycle with `tx_valid_o`=1, `tx_replay_o`=0 and `tx_seq_o` equal to the next send number; send numbers rise by one per accepted flit and wrap from 255 to 0.
- R3: While DEPTH (16) flits are unacknowledged, `up_ready_o` is 0 and no new flit is sent.
- R4: An incoming message (`ackin_valid_i`) naming sequence `s` releases all stored flits up to and including `s` from the next cycle; a message whose `s` lies outside the outstanding window (neither the newest released number nor an outstanding one) changes nothing.
- R5: An incoming message with `ackin_nak_i`=1 and sequence `s` inside the window makes the block, from the next cycle on, send stored flits `s+1` up to the newest, one per cycle in rising order, with `tx_replay_o`=1 and their original data; if nothing is outstanding after the release, no replay starts.
- R6: `up_ready_o` is 0 during a replay; after it ends, upstream traffic resumes with the send number that follows the newest stored flit.
- R7: Replay is repeatable: a later negative acknowledge naming the same sequence replays the same flits again.
- R8: A received flit with `rx_crc_ok_i`=1 and `rx_seq_i` equal to the expected number yields, one cycle later, `rx_accept_o`=1 and an acknowledge (`ackout_nak_o`=0) carrying that number; the expected number then rises by one.
- R9: A received flit with `rx_crc_ok_i`=0 yields one cycle later a negative acknowledge (`ackout_nak_o`=1) carrying the expected number minus one (255 right after reset), with `rx_accept_o`=0, every time it happens.
- R10: A received flit with `rx_crc_ok_i`=1 but a sequence other than the expected one is discarded: no accept, no acknowledge message, and the expected number is unchanged.
- R11: A negative acknowledge that arrives during a replay restarts the replay from the flit after its sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_valid_i | input | 1 | Upstream flit offered |
| up_data_i | input | FLIT_W | Upstream flit |
| up_ready_o | output | 1 | Block takes the upstream flit this cycle |
| tx_valid_o | output | 1 | Flit driven to the link |
| tx_seq_o | output | 8 | Sequence number of the driven flit |
| tx_data_o | output | FLIT_W | Driven flit |
| tx_replay_o | output | 1 | Driven flit is a resend |
| ackin_valid_i | input | 1 | Acknowledge message from the partner |
| ackin_nak_i | input | 1 | 1 = negative acknowledge |
| ackin_seq_i | input | 8 | Sequence number named by the message |
| rx_valid_i | input | 1 | Status of one received flit |
| rx_seq_i | input | 8 | Sequence number of the received flit |
| rx_crc_ok_i | input | 1 | CRC result after correction, 1 = pass |
| rx_accept_o | output | 1 | Received flit accepted in order |
| ackout_valid_o | output | 1 | Acknowledge message to the partner |
| ackout_nak_o | output | 1 | 1 = negative acknowledge |
| ackout_seq_o | output | 8 | Sequence number carried by the message |

## Verification
Several rules are checked on every cycle. The outstanding count never exceeds the store depth, and a full store never lets a new flit through. A message outside the window leaves the release point unchanged. A negative acknowledge with flits pending starts a replay at the right flit. A replay step that nothing interrupts advances by exactly one. On the receive side, a failing CRC is always followed by a negative acknowledge, and a good flit out of order is always followed by silence. Other behaviour is shown only by the bench scenarios: the replayed data matching what was first sent, the exact release boundary seen through `up_ready_o` falling on the sixteenth flit, restart in the middle of a replay, resumption of numbering after a replay, and the wrap of the send number.

// File: rtl/flit_retry_pkg.sv
`timescale 1ns/1ps
package flit_retry_pkg;
  localparam int unsigned SEQ_W = 8;
  typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/replay_buf.sv
`timescale 1ns/1ps
module replay_buf #(
  parameter int unsigned FLIT_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [FLIT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [FLIT_W-1:0] rdata_o
);
  logic [FLIT_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == IDX_W'(e)) mem_q[e] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_retry_ctrl.sv
`timescale 1ns/1ps
module tx_retry_ctrl
  import flit_retry_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_valid_i,
  input  logic fb_valid_i,
  input  logic fb_nak_i,
  input  seq_t fb_seq_i,
  output logic up_ready_o,
  output logic push_o,
  output logic replay_o,
  output seq_t rptr_o,
  output seq_t next_o
);
  seq_t head_q, next_q, rptr_q;
  logic replay_q;
  seq_t head_n, next_n, rptr_n;
  logic replay_n;
  seq_t count, off, dist_r;
  logic full, fb_ok;

  assign count      = next_q - head_q;
  assign full       = (count == seq_t'(DEPTH));
  assign up_ready_o = !replay_q && !full;
  assign push_o     = up_valid_i && up_ready_o;
  // number of flits a message would release; window check
  assign off        = fb_seq_i - head_q + seq_t'(1);
  assign fb_ok      = fb_valid_i && (off <= count);
  assign dist_r     = rptr_q - head_q;

  always_comb begin
    head_n   = fb_ok ? fb_seq_i + seq_t'(1) : head_q;
    next_n   = push_o ? next_q + seq_t'(1) : next_q;
    rptr_n   = rptr_q;
    replay_n = 1'b0;
    if (fb_ok && fb_nak_i) begin
      rptr_n   = head_n;
      replay_n = (head_n != next_n);
    end else if (replay_q) begin
      // an ack that releases the flit in flight moves the pointer past it
      rptr_n   = (fb_ok && off > dist_r) ? head_n : rptr_q + seq_t'(1);
      replay_n = (rptr_n != next_n);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      next_q   <= '0;
      rptr_q   <= '0;
      replay_q <= 1'b0;
    end else begin
      head_q   <= head_n;
      next_q   <= next_n;
      rptr_q   <= rptr_n;
      replay_q <= replay_n;
    end
  end

  assign replay_o = replay_q;
  assign rptr_o   = rptr_q;
  assign next_o   = next_q;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= seq_t'(DEPTH));
  a_r3_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !push_o);
  a_r4_stale_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_valid_i && !fb_ok) |=> head_q == $past(head_q));
  a_r5_replay_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_ok && fb_nak_i && head_n != next_n) |=> (replay_q && rptr_q == head_q));
  a_r5_replay_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_q && !fb_valid_i && rptr_q + seq_t'(1) != next_q) |=>
      (replay_q && rptr_q == $past(rptr_q) + seq_t'(1)));
endmodule

// File: rtl/rx_seq_check.sv
`timescale 1ns/1ps
module rx_seq_check
  import flit_retry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_valid_i,
  input  seq_t rx_seq_i,
  input  logic rx_ok_i,
  output logic accept_o,
  output logic fb_valid_o,
  output logic fb_nak_o,
  output seq_t fb_seq_o
);
  seq_t exp_q;
  logic in_order;

  assign in_order = rx_valid_i && rx_ok_i && (rx_seq_i == exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q      <= '0;
      accept_o   <= 1'b0;
      fb_valid_o <= 1'b0;
      fb_nak_o   <= 1'b0;
      fb_seq_o   <= '0;
    end else begin
      accept_o   <= in_order;
      fb_valid_o <= in_order || (rx_valid_i && !rx_ok_i);
      fb_nak_o   <= rx_valid_i && !rx_ok_i;
      // nak names the last good sequence number
      fb_seq_o   <= in_order ? rx_seq_i : exp_q - seq_t'(1);
      if (in_order) exp_q <= exp_q + seq_t'(1);
    end
  end

  a_r8_accept_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_order |=> (accept_o && fb_valid_o && !fb_nak_o && fb_seq_o == $past(rx_seq_i)));
  a_r9_fail_naks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_ok_i) |=> (fb_valid_o && fb_nak_o && !accept_o));
  a_r10_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ok_i && rx_seq_i != exp_q) |=> (!fb_valid_o && $stable(exp_q)));
endmodule

// File: rtl/flit_retry_ctrl.sv
`timescale 1ns/1ps
module flit_retry_ctrl
  import flit_retry_pkg::*;
#(
  parameter int unsigned FLIT_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic [FLIT_W-1:0] up_data_i,
  output logic              up_ready_o,
  output logic              tx_valid_o,
  output logic [SEQ_W-1:0]  tx_seq_o,
  output logic [FLIT_W-1:0] tx_data_o,
  output logic              tx_replay_o,
  input  logic              ackin_valid_i,
  input  logic              ackin_nak_i,
  input  logic [SEQ_W-1:0]  ackin_seq_i,
  input  logic              rx_valid_i,
  input  logic [SEQ_W-1:0]  rx_seq_i,
  input  logic              rx_crc_ok_i,
  output logic              rx_accept_o,
  output logic              ackout_valid_o,
  output logic              ackout_nak_o,
  output logic [SEQ_W-1:0]  ackout_seq_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic push, replay;
  seq_t rptr, next_seq;
  logic [FLIT_W-1:0] rdata;

  tx_retry_ctrl #(.DEPTH(DEPTH)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_valid_i (up_valid_i),
    .fb_valid_i (ackin_valid_i),
    .fb_nak_i   (ackin_nak_i),
    .fb_seq_i   (ackin_seq_i),
    .up_ready_o (up_ready_o),
    .push_o     (push),
    .replay_o   (replay),
    .rptr_o     (rptr),
    .next_o     (next_seq)
  );

  replay_buf #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (next_seq[IDX_W-1:0]),
    .wdata_i (up_data_i),
    .raddr_i (rptr[IDX_W-1:0]),
    .rdata_o (rdata)
  );

  rx_seq_check u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_seq_i   (rx_seq_i),
    .rx_ok_i    (rx_crc_ok_i),
    .accept_o   (rx_accept_o),
    .fb_valid_o (ackout_valid_o),
    .fb_nak_o   (ackout_nak_o),
    .fb_seq_o   (ackout_seq_o)
  );

  assign tx_valid_o  = replay || push;
  assign tx_replay_o = replay;
  assign tx_seq_o    = replay ? rptr : next_seq;
  assign tx_data_o   = replay ? rdata : up_data_i;

  a_r6_no_new_in_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_replay_o |-> !up_ready_o);
  a_r2_new_seq_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_replay_o) |=> (next_seq == $past(tx_seq_o) + seq_t'(1)));
endmodule

// File: tb/sim_flit_retry_ctrl.sv
`timescale 1ns/1ps
module sim_flit_retry_ctrl;
  localparam int FW  = 32;
  localparam int DEP = 16;

  typedef struct packed {
    logic [7:0] seq;
    logic       ok;
    logic       fbv;
    logic       nak;
    logic [7:0] fseq;
    logic       acc;
  } rxv_t;

  // receive-side vectors: stimulus, then expected response one cycle later
  localparam rxv_t RXT [12] = '{
    '{8'd0, 1'b0, 1'b1, 1'b1, 8'd255, 1'b0},
    '{8'd0, 1'b1, 1'b1, 1'b0, 8'd0,   1'b1},
    '{8'd1, 1'b1, 1'b1, 1'b0, 8'd1,   1'b1},
    '{8'd2, 1'b0, 1'b1, 1'b1, 8'd1,   1'b0},
    '{8'd3, 1'b1, 1'b0, 1'b0, 8'd0,   1'b0},
    '{8'd4, 1'b1, 1'b0, 1'b0, 8'd0,   1'b0},
    '{8'd2, 1'b0, 1'b1, 1'b1, 8'd1,   1'b0},
    '{8'd2, 1'b1, 1'b1, 1'b0, 8'd2,   1'b1},
    '{8'd3, 1'b1, 1'b1, 1'b0, 8'd3,   1'b1},
    '{8'd3, 1'b1, 1'b0, 1'b0, 8'd0,   1'b0},
    '{8'd4, 1'b0, 1'b1, 1'b1, 8'd3,   1'b0},
    '{8'd4, 1'b1, 1'b1, 1'b0, 8'd4,   1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0;
  logic [FW-1:0] up_data = '0;
  logic up_ready, tx_valid, tx_replay;
  logic [7:0] tx_seq;
  logic [FW-1:0] tx_data;
  logic ackin_valid = 1'b0, ackin_nak = 1'b0;
  logic [7:0] ackin_seq = '0;
  logic rx_valid = 1'b0, rx_ok = 1'b0;
  logic [7:0] rx_seq = '0;
  logic rx_accept, ackout_valid, ackout_nak;
  logic [7:0] ackout_seq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flit_retry_ctrl #(.FLIT_W(FW), .DEPTH(DEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .up_valid_i(up_valid), .up_data_i(up_data), .up_ready_o(up_ready),
    .tx_valid_o(tx_valid), .tx_seq_o(tx_seq), .tx_data_o(tx_data), .tx_replay_o(tx_replay),
    .ackin_valid_i(ackin_valid), .ackin_nak_i(ackin_nak), .ackin_seq_i(ackin_seq),
    .rx_valid_i(rx_valid), .rx_seq_i(rx_seq), .rx_crc_ok_i(rx_ok),
    .rx_accept_o(rx_accept), .ackout_valid_o(ackout_valid), .ackout_nak_o(ackout_nak),
    .ackout_seq_o(ackout_seq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_chk(input logic [FW-1:0] d, input logic [7:0] es, input string req);
    @(negedge clk);
    up_valid = 1'b1;
    up_data  = d;
    #1;
    chk({req, " ready"}, 64'(up_ready), 64'd1);
    chk({req, " valid"}, 64'(tx_valid), 64'd1);
    chk({req, " seq"},   64'(tx_seq),   64'(es));
    chk({req, " data"},  64'(tx_data),  64'(d));
    @(posedge clk);
    #1 up_valid = 1'b0;
  endtask

  task automatic ackin(input logic nak, input logic [7:0] s);
    @(negedge clk);
    ackin_valid = 1'b1;
    ackin_nak   = nak;
    ackin_seq   = s;
    @(posedge clk);
    #1 ackin_valid = 1'b0;
  endtask

  task automatic replay_chk(input int s, input string req);
    @(negedge clk);
    chk({req, " rvalid"}, 64'(tx_valid),  64'd1);
    chk({req, " rflag"},  64'(tx_replay), 64'd1);
    chk({req, " rseq"},   64'(tx_seq),    64'(s[7:0]));
    chk({req, " rdata"},  64'(tx_data),   64'(32'h1000 + s));
    chk("R6 ready low in replay", 64'(up_ready), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready",  64'(up_ready),     64'd1);
    chk("R1 tx",     64'(tx_valid),     64'd0);
    chk("R1 ackout", 64'(ackout_valid), 64'd0);
    chk("R1 accept", 64'(rx_accept),    64'd0);

    // receive side table
    for (int i = 0; i < 12; i++) begin
      string rq;
      rq = RXT[i].acc ? "R8" : (RXT[i].nak ? "R9" : "R10");
      @(negedge clk);
      rx_valid = 1'b1;
      rx_seq   = RXT[i].seq;
      rx_ok    = RXT[i].ok;
      @(negedge clk);
      rx_valid = 1'b0;
      chk({rq, " fb valid"}, 64'(ackout_valid), 64'(RXT[i].fbv));
      chk({rq, " accept"},   64'(rx_accept),    64'(RXT[i].acc));
      if (RXT[i].fbv) begin
        chk({rq, " nak"}, 64'(ackout_nak), 64'(RXT[i].nak));
        chk({rq, " seq"}, 64'(ackout_seq), 64'(RXT[i].fseq));
      end
    end

    // send side
    for (int i = 0; i < 4; i++) push_chk(32'h1000 + i, 8'(i), "R2");
    ackin(1'b0, 8'd1);                      // R4: releases 0 and 1
    for (int i = 4; i < 18; i++) push_chk(32'h1000 + i, 8'(i), "R4");
    @(negedge clk);
    up_valid = 1'b1;
    #1;
    chk("R3 ready when full", 64'(up_ready), 64'd0);
    chk("R3 no send when full", 64'(tx_valid), 64'd0);
    @(posedge clk);
    #1 up_valid = 1'b0;
    ackin(1'b0, 8'd200);                    // outside window
    @(negedge clk);
    chk("R4 stale ack ignored", 64'(up_ready), 64'd0);

    ackin(1'b1, 8'd5);                      // releases 2..5, replays 6..17
    for (int s = 6; s < 18; s++) replay_chk(s, "R5");
    @(negedge clk);
    chk("R5 replay ends", 64'(tx_valid), 64'd0);
    chk("R6 ready after replay", 64'(up_ready), 64'd1);

    ackin(1'b1, 8'd5);                      // same nak again
    for (int s = 6; s < 9; s++) replay_chk(s, "R7");
    ackin_valid = 1'b1;                     // nak mid-replay
    ackin_nak   = 1'b1;
    ackin_seq   = 8'd7;
    @(posedge clk);
    #1 ackin_valid = 1'b0;
    for (int s = 8; s < 18; s++) replay_chk(s, "R11");
    @(negedge clk);
    chk("R11 replay ends", 64'(tx_valid), 64'd0);

    push_chk(32'h1000 + 18, 8'd18, "R6 resume");
    ackin(1'b0, 8'd18);
    ackin(1'b1, 8'd18);                     // nothing outstanding
    @(negedge clk);
    chk("R5 no replay when empty", 64'(tx_valid), 64'd0);
    chk("R5 ready when empty",     64'(up_ready), 64'd1);

    for (int i = 19; i < 262; i++) begin    // wrap 255 -> 0
      push_chk(32'h1000 + i, 8'(i), "R2 wrap");
      ackin(1'b0, 8'(i));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule